// File: doc/BRIEF.md
# OR-Combining Indexed Address Generator

This block forms the operand bit address for a bit-serial processor. Each 13-bit instruction carries an absolute/relative flag, a bank-select bit and a 7-bit offset. An absolute access places the offset in the lowest 128 bit addresses. A relative access builds the address from one of two 16-bit index registers, bitwise-ORed with the offset. Because no adder is used, a region reached through an index register is a self-aligned, power-of-two block.

The block holds both index registers. The bank-select bit picks the active register for relative addressing. The other register is mapped into the bit address space at addresses 1 through 16, where the surrounding memory logic can read or write it one bit at a time through a small bus port. This arrangement means the active register is never reachable through the map, so it cannot be rewritten while it is in use.

Top module: `or_index_agu`

## Requirements
- R1: The instruction splits as opcode in bits 12:9, absolute flag in bit 8, bank select in bit 7 and offset in bits 6:0; the opcode never changes any output.
- R2: With the absolute flag at 1, `eff_addr` equals the offset zero-extended to 16 bits.
- R3: With the absolute flag at 0, `eff_addr` equals the active index register bitwise-ORed with the zero-extended offset, with no carry between bits.
- R4: `bus_hit` is 1 exactly when `bus_addr` lies in 1..16; bus address 1 maps bit 0 of the mapped register and address 16 maps bit 15. On a hit `bus_rdata` returns that bit, otherwise it is 0.
- R5: When `bus_we` is 1 on a hit, the rising clock edge writes `bus_wdata` into only the addressed bit of the mapped register; the new value shows in addresses formed from the next cycle on.
- R6: A bus write never changes the active index register, even when it falls in the same cycle as a relative address formed from that register.
- R7: A bus write with `bus_addr` outside 1..16 changes neither index register.
- R8: A synchronous reset clears both index registers to zero.
- R9: Bank select 0 makes register A active and maps register B; bank select 1 makes register B active and maps register A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 13 | Current instruction word |
| bus_addr | input | 16 | Bit address of the memory access |
| bus_we | input | 1 | Bit write strobe |
| bus_wdata | input | 1 | Bit to write |
| eff_addr | output | 16 | Effective bit address of the operand |
| bus_hit | output | 1 | Access falls on the mapped index register |
| bus_rdata | output | 1 | Mapped register bit read back, 0 on a miss |

## Verification
A relative address computed from the active register and a bus write into the mapped register can happen in the same cycle. The bench provokes this by issuing a relative instruction while a write strikes the mapped register. It checks that the address in that cycle and in the next one still reflects the unchanged active register. Then it flips the bank select and verifies that the written bit now appears in the relative address built from the other register.

// File: rtl/ixagu_pkg.sv
`timescale 1ns/1ps
package ixagu_pkg;
  localparam int unsigned IX_ADDR_W  = 16;
  localparam int unsigned IX_FIELD_W = 7;
  localparam int unsigned IX_OPC_W   = 4;
  localparam int unsigned IX_INSTR_W = IX_OPC_W + 2 + IX_FIELD_W;
  localparam int unsigned IX_POS_W   = $clog2(IX_ADDR_W);
  localparam int unsigned IX_MAP_LO  = 1;
  localparam int unsigned IX_MAP_HI  = IX_MAP_LO + IX_ADDR_W - 1;

  typedef logic [IX_ADDR_W-1:0]  ix_addr_t;
  typedef logic [IX_FIELD_W-1:0] ix_field_t;
  typedef logic [IX_POS_W-1:0]   ix_pos_t;

  typedef struct packed {
    logic [IX_OPC_W-1:0] opcode;
    logic                absolute;
    logic                bank;
    ix_field_t           offset;
  } ix_instr_t;

  function automatic ix_addr_t ix_zext(input ix_field_t f);
    return ix_addr_t'(f);
  endfunction

  function automatic ix_addr_t ix_or_combine(input ix_addr_t base, input ix_field_t f);
    return base | ix_zext(f);
  endfunction

  function automatic logic ix_in_map(input ix_addr_t a);
    return (a >= ix_addr_t'(IX_MAP_LO)) && (a <= ix_addr_t'(IX_MAP_HI));
  endfunction

  function automatic ix_pos_t ix_map_pos(input ix_addr_t a);
    ix_addr_t d;
    d = a - ix_addr_t'(IX_MAP_LO);
    return d[IX_POS_W-1:0];
  endfunction
endpackage

// File: rtl/ixagu_decode.sv
`timescale 1ns/1ps
module ixagu_decode
  import ixagu_pkg::*;
#(
  parameter int unsigned INSTR_W = IX_INSTR_W
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               absolute,
  output logic               bank,
  output ix_field_t          offset
);
  ix_instr_t word;
  logic      unused_opcode;

  assign word          = ix_instr_t'(instr);
  assign absolute      = word.absolute;
  assign bank          = word.bank;
  assign offset        = word.offset;
  assign unused_opcode = ^word.opcode;
endmodule

// File: rtl/ixagu_bank.sv
`timescale 1ns/1ps
module ixagu_bank
  import ixagu_pkg::*;
#(
  parameter int unsigned ADDR_W = IX_ADDR_W,
  parameter int unsigned BANKS  = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bank,
  input  ix_addr_t bus_addr,
  input  logic     bus_we,
  input  logic     bus_wdata,
  output ix_addr_t active_val,
  output logic     bus_hit,
  output logic     bus_rdata,
  output logic     wr_fire,
  output ix_addr_t reg_a,
  output ix_addr_t reg_b
);
  ix_addr_t idx_q [BANKS];
  ix_addr_t mapped_val;
  ix_pos_t  pos;

  assign bus_hit = ix_in_map(bus_addr);
  assign pos     = ix_map_pos(bus_addr);
  assign wr_fire = bus_we && bus_hit;

  for (genvar g = 0; g < BANKS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        idx_q[g] <= '0;
      end else if (wr_fire && (bank != 1'(g))) begin
        idx_q[g][pos] <= bus_wdata;
      end
    end
  end

  assign active_val = idx_q[bank];
  assign mapped_val = idx_q[~bank];
  assign bus_rdata  = bus_hit ? mapped_val[pos] : 1'b0;
  assign reg_a      = idx_q[0];
  assign reg_b      = idx_q[1];
endmodule

// File: rtl/ixagu_combine.sv
`timescale 1ns/1ps
module ixagu_combine
  import ixagu_pkg::*;
(
  input  logic      absolute,
  input  ix_field_t offset,
  input  ix_addr_t  base,
  output ix_addr_t  eff_addr
);
  always_comb begin
    if (absolute) eff_addr = ix_zext(offset);
    else          eff_addr = ix_or_combine(base, offset);
  end
endmodule

// File: rtl/or_index_agu.sv
`timescale 1ns/1ps
module or_index_agu
  import ixagu_pkg::*;
#(
  parameter int unsigned ADDR_W  = IX_ADDR_W,
  parameter int unsigned INSTR_W = IX_INSTR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic               bus_wdata,
  output logic [ADDR_W-1:0]  eff_addr,
  output logic               bus_hit,
  output logic               bus_rdata
);
  logic      absolute;
  logic      bank;
  ix_field_t offset;
  ix_addr_t  active_val;
  logic      wr_fire;
  ix_addr_t  reg_a;
  ix_addr_t  reg_b;

  ixagu_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr(instr), .absolute(absolute), .bank(bank), .offset(offset)
  );

  ixagu_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst(rst), .bank(bank), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .active_val(active_val),
    .bus_hit(bus_hit), .bus_rdata(bus_rdata), .wr_fire(wr_fire),
    .reg_a(reg_a), .reg_b(reg_b)
  );

  ixagu_combine u_comb (
    .absolute(absolute), .offset(offset), .base(active_val), .eff_addr(eff_addr)
  );
endmodule

// File: rtl/or_index_agu_chk.sv
`timescale 1ns/1ps
module or_index_agu_chk (
  input logic        clk,
  input logic        rst,
  input logic [12:0] instr,
  input logic [15:0] bus_addr,
  input logic        bus_we,
  input logic        bus_wdata,
  input logic [15:0] eff_addr,
  input logic        bus_hit,
  input logic        bus_rdata,
  input logic        wr_fire,
  input logic [15:0] reg_a,
  input logic [15:0] reg_b
);
  logic        abs_f;
  logic        bank_f;
  logic [15:0] off_x;
  logic [3:0]  bpos;
  logic [15:0] mapped;

  assign abs_f  = instr[8];
  assign bank_f = instr[7];
  assign off_x  = {9'd0, instr[6:0]};
  assign bpos   = 4'(bus_addr - 16'd1);
  assign mapped = bank_f ? reg_a : reg_b;

  a_r2_absolute: assert property (@(posedge clk) disable iff (rst)
    abs_f |-> eff_addr == off_x);
  a_r3_or_relative: assert property (@(posedge clk) disable iff (rst)
    !abs_f |-> eff_addr == ((bank_f ? reg_b : reg_a) | off_x));
  a_r4_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_hit |-> !bus_rdata);
  a_r4_read_bit: assert property (@(posedge clk) disable iff (rst)
    bus_hit |-> bus_rdata == mapped[bpos]);
  a_r5_write_b: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !bank_f) |=> reg_b[$past(bpos)] == $past(bus_wdata));
  a_r5_write_a: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && bank_f) |=> reg_a[$past(bpos)] == $past(bus_wdata));
  a_r6_active_a_held: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !bank_f) |=> $stable(reg_a));
  a_r6_active_b_held: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && bank_f) |=> $stable(reg_b));
  a_r7_no_stray: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_hit) |=> ($stable(reg_a) && $stable(reg_b)));
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (reg_a == 16'd0 && reg_b == 16'd0));
endmodule

bind or_index_agu or_index_agu_chk u_chk (
  .clk(clk), .rst(rst), .instr(instr), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .eff_addr(eff_addr), .bus_hit(bus_hit),
  .bus_rdata(bus_rdata), .wr_fire(wr_fire), .reg_a(reg_a), .reg_b(reg_b)
);

// File: tb/or_index_agu_test.sv
`timescale 1ns/1ps
module or_index_agu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] instr = '0;
  logic [15:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic        bus_wdata = 1'b0;
  logic [15:0] eff_addr;
  logic        bus_hit;
  logic        bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] ea;
    logic        hit;
    logic        rd;
    string       tag;
  } item_t;
  item_t sb[$];

  logic [15:0] model [2];

  always #4 clk = ~clk;

  or_index_agu uut (
    .clk(clk), .rst(rst), .instr(instr), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .eff_addr(eff_addr), .bus_hit(bus_hit), .bus_rdata(bus_rdata)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] opc, input logic abs_f, input logic bank_f,
                      input logic [6:0] off, input logic [15:0] ba, input logic we,
                      input logic wd, input string tag);
    item_t it;
    logic [15:0] ext;
    logic [15:0] mp;
    @(negedge clk);
    instr = {opc, abs_f, bank_f, off};
    bus_addr = ba; bus_we = we; bus_wdata = wd;
    ext = {9'd0, off};
    it.ea  = abs_f ? ext : (model[bank_f] | ext);
    it.hit = (ba >= 16'd1) && (ba <= 16'd16);
    mp = model[~bank_f];
    it.rd  = it.hit ? mp[ba - 16'd1] : 1'b0;
    it.tag = tag;
    sb.push_back(it);
    if (we && it.hit) model[~bank_f][ba - 16'd1] = wd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_we = 1'b0;
    @(posedge clk); @(posedge clk);
    model[0] = '0; model[1] = '0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(input logic bank_f, input logic [15:0] v);
    for (int i = 0; i < 16; i++)
      step(4'h3, 1'b1, bank_f, 7'd0, 16'(i + 1), 1'b1, v[i], "R5");
  endtask

  task automatic read_all(input logic bank_f, input string tag);
    for (int i = 0; i < 16; i++)
      step(4'h1, 1'b1, bank_f, 7'd0, 16'(i + 1), 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares each pushed item late in the same cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t e;
        e = sb.pop_front();
        check(eff_addr === e.ea, e.tag, "eff_addr", eff_addr, e.ea);
        check(bus_hit === e.hit, e.tag, "bus_hit", 16'(bus_hit), 16'(e.hit));
        check(bus_rdata === e.rd, e.tag, "bus_rdata", 16'(bus_rdata), 16'(e.rd));
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    model[0] = '0; model[1] = '0;
    do_reset();
    // R8: reset state
    step(4'h0, 1'b0, 1'b0, 7'd0, 16'd0, 1'b0, 1'b0, "R8");
    read_all(1'b0, "R8");
    read_all(1'b1, "R8");
    // R5 R9: load B via bank 0, A via bank 1
    load(1'b0, 16'h5A00);
    load(1'b1, 16'h0381);
    read_all(1'b0, "R4_R9");
    read_all(1'b1, "R4_R9");
    // R4 boundaries
    step(4'h2, 1'b1, 1'b0, 7'd0, 16'd0,  1'b0, 1'b0, "R4");
    step(4'h2, 1'b1, 1'b0, 7'd0, 16'd17, 1'b0, 1'b0, "R4");
    step(4'h2, 1'b1, 1'b1, 7'd0, 16'd16, 1'b0, 1'b0, "R4");
    // R2 / R1: absolute, opcode varied
    step(4'hF, 1'b1, 1'b1, 7'h7F, 16'd0, 1'b0, 1'b0, "R2");
    step(4'h0, 1'b1, 1'b0, 7'h55, 16'd0, 1'b0, 1'b0, "R2");
    step(4'hA, 1'b1, 1'b0, 7'h55, 16'd0, 1'b0, 1'b0, "R1");
    // R3 / R9: OR, no carry (0x0381|0x03 = 0x0383)
    step(4'h4, 1'b0, 1'b0, 7'h03, 16'd0, 1'b0, 1'b0, "R3");
    step(4'h4, 1'b0, 1'b1, 7'h7F, 16'd0, 1'b0, 1'b0, "R9");
    step(4'hC, 1'b0, 1'b1, 7'h7F, 16'd0, 1'b0, 1'b0, "R1");
    step(4'h4, 1'b0, 1'b0, 7'h7F, 16'd0, 1'b0, 1'b0, "R3");
    // R7: stray writes
    step(4'h5, 1'b1, 1'b0, 7'd0, 16'd0,     1'b1, 1'b1, "R7");
    step(4'h5, 1'b1, 1'b1, 7'd0, 16'd17,    1'b1, 1'b1, "R7");
    step(4'h5, 1'b1, 1'b0, 7'd0, 16'hFFFF,  1'b1, 1'b1, "R7");
    step(4'h5, 1'b1, 1'b1, 7'd0, 16'h0080,  1'b1, 1'b1, "R7");
    read_all(1'b0, "R7");
    read_all(1'b1, "R7");
    // R6: same-cycle write to mapped B while relative on active A
    step(4'h6, 1'b0, 1'b0, 7'd0, 16'd5, 1'b1, 1'b1, "R6");
    step(4'h6, 1'b0, 1'b0, 7'd0, 16'd0, 1'b0, 1'b0, "R6");
    step(4'h6, 1'b0, 1'b1, 7'd0, 16'd0, 1'b0, 1'b0, "R5");
    // R6: write A bit 0 while relative on active B
    step(4'h6, 1'b0, 1'b1, 7'd0, 16'd1, 1'b1, 1'b0, "R6");
    step(4'h6, 1'b0, 1'b1, 7'd0, 16'd0, 1'b0, 1'b0, "R6");
    step(4'h6, 1'b0, 1'b0, 7'd0, 16'd0, 1'b0, 1'b0, "R5");
    // R8: mid-run reset
    do_reset();
    read_all(1'b0, "R8");
    read_all(1'b1, "R8");
    step(4'h7, 1'b0, 1'b1, 7'h11, 16'd0, 1'b0, 1'b0, "R8");
    @(negedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule